// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for an 8-bit microcontroller core and tells the CPU which service routine to enter. There are fifteen maskable vector slots and one unmaskable software-break source. The fifteen slots are fed by sixteen hardware events, because two events share one slot. Every slot has a request latch and an enable bit. A slot is masked when the CPU status register's global disable flag, supplied on an input, is high. When several slots are pending at once, the controller chooses among them by fixed priority. It then drives a request line and the 16-bit address of the winning vector's low byte. The high byte of the vector sits at that address plus one.

The controller conditions the external pins itself. Each external request pin passes through a two-flop synchronizer and an edge detector, and software selects whether it reacts to the rising or the falling edge. A key-wake source watches the AND of every port pin configured as an input and fires when that AND falls. A select input decides whether the timer-trigger pin or the converter-done pulse feeds the shared slot. The CPU acknowledges the vector it is taking. The controller then clears the winning latch and pulses an output telling the CPU to set its global disable flag. Pushing state to the stack and fetching the vector remain the CPU's job.

Top module: `pic_vec_ctrl`

## Requirements
- R1: While `rst_n` is low, `irq_o` is 1 and `vec_o` is 0xFFFC. After release, every request latch, enable bit and the break latch read 0, and `irq_o` is 0.
- R2: A slot takes part in arbitration only when its request latch is 1, its enable bit is 1 and `gdis_i` is 0.
- R3: A one-cycle `brk_i` pulse latches a break request. This request raises `irq_o` with `vec_o` = 0xFFDC whatever the enables and `gdis_i` are. Break ranks below every slot.
- R4: The slot order from highest to lowest is: 0 ext pin 0, 1 ext pin 1, 2 serial-1 receive, 3 serial-1 transmit, 4 timer `tmr_uf_i[0]`, 5 timer `tmr_uf_i[1]`, 6 timer `tmr_uf_i[2]`, 7 timer `tmr_uf_i[3]`, 8 ext pin 3, 9 ext pin 4, 10 timer `tmr_uf_i[4]`, 11 ext pin 2, 12 serial-2, 13 key wake, 14 converter/trigger. The lowest-numbered eligible slot k wins, and `vec_o` is 0xFFFA − 2k. Bit k of `req_o`, `en_wdata_i` and `req_wdata_i` belongs to slot k.
- R5: A pulse on `en_wr_i` loads all enables from `en_wdata_i`. A pulse on `req_wr_i` clears each latch whose `req_wdata_i` bit is 0. A 1 bit leaves its latch unchanged, so software can never set a request.
- R6: When a source event and a software clear reach the same latch in the same cycle, the latch ends up set.
- R7: When `ack_i` is high while `irq_o` is high, `idis_set_o` is 1 in that same cycle and only the winning latch (slot or break) is cleared at the next edge. With `irq_o` low, `idis_set_o` stays 0.
- R8: Each external pin is synchronized and sets its latch on a rising edge when its `ext_rise_i` bit is 1, and on a falling edge when it is 0. The opposite edge is ignored. After a pin changes just after an edge, `req_o` shows the request after the third rising clock edge and not after the second.
- R9: The key-wake slot is set when the AND of all `key_pin_i` bits whose `key_inmode_i` bit is 1 falls from 1 to 0. Pins whose mode bit is 0 are ignored.
- R10: When `ad_sel_i` is 1, an `ad_done_i` pulse sets slot 14 and the trigger pin is ignored. When `ad_sel_i` is 0, a falling edge on `adt_pin_i` sets slot 14 and `ad_done_i` is ignored.
- R11: The serial-1 pulses set their slots only while `sio1_sel_i` is 1, and the serial-2 pulse sets its slot only while `sio2_sel_i` is 1.
- R12: A timer, serial or converter pulse high at a rising clock edge sets its latch at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; presents the reset vector while low |
| gdis_i | input | 1 | Global disable flag from the CPU status register |
| brk_i | input | 1 | Software break pulse |
| ext_pin_i | input | 5 | External request pins 0..4 |
| ext_rise_i | input | 5 | Edge select per external pin, 1 = rising, 0 = falling |
| tmr_uf_i | input | 5 | Timer underflow pulses |
| sio1_sel_i | input | 1 | Serial-1 function selected |
| sio1_rx_i | input | 1 | Serial-1 receive complete pulse |
| sio1_tx_i | input | 1 | Serial-1 transmit done pulse |
| sio2_sel_i | input | 1 | Serial-2 function selected |
| sio2_done_i | input | 1 | Serial-2 transfer done pulse |
| key_pin_i | input | KEY_W | Key-wake port pins |
| key_inmode_i | input | KEY_W | Per-pin input mode, 1 = input |
| adt_pin_i | input | 1 | Conversion trigger pin |
| ad_done_i | input | 1 | Conversion complete pulse |
| ad_sel_i | input | 1 | Shared-slot source select, 1 = conversion complete |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 15 | New enable bits |
| req_wr_i | input | 1 | Request clear strobe |
| req_wdata_i | input | 15 | Request write data, 0 clears |
| ack_i | input | 1 | CPU accepts the presented vector |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector low-byte address |
| idis_set_o | output | 1 | CPU must set its global disable flag |
| req_o | output | 15 | Current request latches |

## Verification
The bench checks that a masked or disabled slot never hides the unmaskable break. A design that gated break with the enable or the flag would leave `irq_o` low with a break pending. It collides a timer pulse with a software clear to the same latch in one cycle. A design that let the clear win would drop a real event. It acknowledges a vector while two slots are pending to confirm that only the winner is cleared, and it also acknowledges with nothing pending, where a careless design would still ask the CPU to mask. It times the external-pin path edge by edge and drives the ignored edge polarity, the output-mode key pins, the unselected half of the shared slot and the deselected serial sources, each of which a wrong design would turn into a spurious request.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NSLOT    = 15;
    localparam int NEXT     = 5;
    localparam int NTMR     = 5;
    localparam int VEC_W    = 16;
    localparam int SLOT_IW  = $clog2(NSLOT);

    localparam logic [VEC_W-1:0] VEC_RESET = 16'hFFFC;
    localparam logic [VEC_W-1:0] VEC_FIRST = 16'hFFFA;
    localparam logic [VEC_W-1:0] VEC_BRK   = 16'hFFDC;

    // slot numbers, highest priority first
    localparam int SL_EXT0  = 0;
    localparam int SL_EXT1  = 1;
    localparam int SL_S1RX  = 2;
    localparam int SL_S1TX  = 3;
    localparam int SL_TMR0  = 4;
    localparam int SL_TMR1  = 5;
    localparam int SL_TMR2  = 6;
    localparam int SL_TMR3  = 7;
    localparam int SL_EXT3  = 8;
    localparam int SL_EXT4  = 9;
    localparam int SL_TMR4  = 10;
    localparam int SL_EXT2  = 11;
    localparam int SL_S2    = 12;
    localparam int SL_KEY   = 13;
    localparam int SL_CONV  = 14;

    typedef logic [NSLOT-1:0] slot_vec_t;

    typedef struct packed {
        slot_vec_t req;
        slot_vec_t en;
        logic      brk;
    } pic_state_t;

    function automatic logic [VEC_W-1:0] slot_vector(input logic [SLOT_IW-1:0] k);
        return VEC_FIRST - (VEC_W'(k) << 1);
    endfunction

endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } det_t;

    det_t det_d, det_q;
    logic now_lvl;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[STAGES-2:0], din};
        det_d.prev = det_q.sync[STAGES-1];
        now_lvl    = det_q.sync[STAGES-1];
        edge_o     = rise_sel ? (now_lvl & ~det_q.prev) : (~now_lvl & det_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.sync <= {STAGES{RST_VAL}};
            det_q.prev <= RST_VAL;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/pic_key_merge.sv
module pic_key_merge #(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] pins,
    input  logic [KEY_W-1:0] inmode,
    output logic             all_high
);

    logic [KEY_W-1:0] masked;

    always_comb begin
        masked   = pins | ~inmode;
        all_high = &masked;
    end

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N  = 15,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) idx = IW'(k);
        end
    end

endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl
    import pic_pkg::*;
#(
    parameter int KEY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gdis_i,
    input  logic             brk_i,
    input  logic [NEXT-1:0]  ext_pin_i,
    input  logic [NEXT-1:0]  ext_rise_i,
    input  logic [NTMR-1:0]  tmr_uf_i,
    input  logic             sio1_sel_i,
    input  logic             sio1_rx_i,
    input  logic             sio1_tx_i,
    input  logic             sio2_sel_i,
    input  logic             sio2_done_i,
    input  logic [KEY_W-1:0] key_pin_i,
    input  logic [KEY_W-1:0] key_inmode_i,
    input  logic             adt_pin_i,
    input  logic             ad_done_i,
    input  logic             ad_sel_i,
    input  logic             en_wr_i,
    input  logic [NSLOT-1:0] en_wdata_i,
    input  logic             req_wr_i,
    input  logic [NSLOT-1:0] req_wdata_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             idis_set_o,
    output logic [NSLOT-1:0] req_o
);

    pic_state_t state_d, state_q;

    logic [NEXT-1:0]    ext_edge;
    logic               key_all_high;
    logic               key_fall;
    logic               adt_fall;
    slot_vec_t          set_vec;
    slot_vec_t          pend_eff;
    logic               win_any;
    logic [SLOT_IW-1:0] win_idx;
    logic               irq_raw;
    logic               accept;

    // external pins: synchronizer plus selectable edge
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        pic_edge_det #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b0)
        ) i_ext_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (ext_pin_i[g]),
            .rise_sel (ext_rise_i[g]),
            .edge_o   (ext_edge[g])
        );
    end

    pic_key_merge #(
        .KEY_W (KEY_W)
    ) i_key_merge (
        .pins     (key_pin_i),
        .inmode   (key_inmode_i),
        .all_high (key_all_high)
    );

    pic_edge_det #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_key_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (key_all_high),
        .rise_sel (1'b0),
        .edge_o   (key_fall)
    );

    pic_edge_det #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_adt_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (adt_pin_i),
        .rise_sel (1'b0),
        .edge_o   (adt_fall)
    );

    pic_prio_enc #(
        .N (NSLOT)
    ) i_prio (
        .pend (pend_eff),
        .any  (win_any),
        .idx  (win_idx)
    );

    // source events mapped onto slots
    always_comb begin
        set_vec           = '0;
        set_vec[SL_EXT0]  = ext_edge[0];
        set_vec[SL_EXT1]  = ext_edge[1];
        set_vec[SL_EXT2]  = ext_edge[2];
        set_vec[SL_EXT3]  = ext_edge[3];
        set_vec[SL_EXT4]  = ext_edge[4];
        set_vec[SL_S1RX]  = sio1_sel_i & sio1_rx_i;
        set_vec[SL_S1TX]  = sio1_sel_i & sio1_tx_i;
        set_vec[SL_TMR0]  = tmr_uf_i[0];
        set_vec[SL_TMR1]  = tmr_uf_i[1];
        set_vec[SL_TMR2]  = tmr_uf_i[2];
        set_vec[SL_TMR3]  = tmr_uf_i[3];
        set_vec[SL_TMR4]  = tmr_uf_i[4];
        set_vec[SL_S2]    = sio2_sel_i & sio2_done_i;
        set_vec[SL_KEY]   = key_fall;
        set_vec[SL_CONV]  = ad_sel_i ? ad_done_i : adt_fall;
    end

    // arbitration, acceptance and next state
    always_comb begin
        slot_vec_t keep;
        slot_vec_t clr;
        logic      brk_clr;

        pend_eff = state_q.req & state_q.en & {NSLOT{~gdis_i}};
        irq_raw  = win_any | state_q.brk;
        accept   = ack_i & irq_raw & rst_n;

        keep    = req_wr_i ? req_wdata_i : '1;
        clr     = '0;
        brk_clr = 1'b0;
        if (accept) begin
            if (win_any) clr[win_idx] = 1'b1;
            else         brk_clr      = 1'b1;
        end

        state_d     = state_q;
        if (en_wr_i) state_d.en = en_wdata_i;
        state_d.req = (state_q.req & keep & ~clr) | set_vec;
        state_d.brk = (state_q.brk & ~brk_clr) | brk_i;

        irq_o      = ~rst_n | irq_raw;
        idis_set_o = accept;
        req_o      = state_q.req;
        if (!rst_n)       vec_o = VEC_RESET;
        else if (win_any) vec_o = slot_vector(win_idx);
        else              vec_o = VEC_BRK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pic_vec_ctrl_chk.sv
module pic_vec_ctrl_chk
    import pic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             gdis_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             idis_set_o,
    input logic [NSLOT-1:0] req_o,
    input logic [NSLOT-1:0] en_q,
    input logic             brk_q
);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_vec_R1: assert (irq_o && vec_o == VEC_RESET)
                else $error("reset vector not presented");
        end
    end

    assert_pending_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(req_o & en_q)) && !gdis_i) |-> irq_o)
        else $error("eligible slot did not raise irq");

    assert_masked_only_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gdis_i && irq_o) |-> (vec_o == VEC_BRK))
        else $error("masked request reached the CPU");

    assert_break_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> irq_o)
        else $error("pending break not presented");

    assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !gdis_i) |-> (vec_o[0] == 1'b0 && vec_o >= VEC_BRK && vec_o <= VEC_FIRST))
        else $error("vector outside slot table");

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idis_set_o |-> (irq_o && ack_i))
        else $error("disable request without acceptance");

endmodule

bind pic_vec_ctrl pic_vec_ctrl_chk i_pic_vec_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gdis_i     (gdis_i),
    .ack_i      (ack_i),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .idis_set_o (idis_set_o),
    .req_o      (req_o),
    .en_q       (state_q.en),
    .brk_q      (state_q.brk)
);

// File: tb/test_pic_vec_ctrl.sv
module test_pic_vec_ctrl;

    localparam int KW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gdis_i = 1'b0, brk_i = 1'b0;
    logic [4:0]  ext_pin_i = '0, ext_rise_i = '1, tmr_uf_i = '0;
    logic        sio1_sel_i = 1'b1, sio1_rx_i = 1'b0, sio1_tx_i = 1'b0;
    logic        sio2_sel_i = 1'b1, sio2_done_i = 1'b0;
    logic [KW-1:0] key_pin_i = '1, key_inmode_i = '1;
    logic        adt_pin_i = 1'b1, ad_done_i = 1'b0, ad_sel_i = 1'b1;
    logic        en_wr_i = 1'b0, req_wr_i = 1'b0, ack_i = 1'b0;
    logic [14:0] en_wdata_i = '0, req_wdata_i = '1;
    logic        irq_o, idis_set_o;
    logic [15:0] vec_o;
    logic [14:0] req_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pic_vec_ctrl i_pic_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .gdis_i(gdis_i), .brk_i(brk_i),
        .ext_pin_i(ext_pin_i), .ext_rise_i(ext_rise_i), .tmr_uf_i(tmr_uf_i),
        .sio1_sel_i(sio1_sel_i), .sio1_rx_i(sio1_rx_i), .sio1_tx_i(sio1_tx_i),
        .sio2_sel_i(sio2_sel_i), .sio2_done_i(sio2_done_i),
        .key_pin_i(key_pin_i), .key_inmode_i(key_inmode_i),
        .adt_pin_i(adt_pin_i), .ad_done_i(ad_done_i), .ad_sel_i(ad_sel_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .req_wr_i(req_wr_i), .req_wdata_i(req_wdata_i), .ack_i(ack_i),
        .irq_o(irq_o), .vec_o(vec_o), .idis_set_o(idis_set_o), .req_o(req_o)
    );

    // {pend[15], en[15], gdis, irq, vec[16]}
    localparam logic [47:0] TBL [11] = '{
        {15'h0001, 15'h7FFF, 1'b0, 1'b1, 16'hFFFA},
        {15'h4000, 15'h7FFF, 1'b0, 1'b1, 16'hFFDE},
        {15'h4100, 15'h7FFF, 1'b0, 1'b1, 16'hFFEA},
        {15'h0C00, 15'h0800, 1'b0, 1'b1, 16'hFFE4},
        {15'h0006, 15'h7FFF, 1'b1, 1'b0, 16'h0000},
        {15'h2000, 15'h0000, 1'b0, 1'b0, 16'h0000},
        {15'h1010, 15'h7FFF, 1'b0, 1'b1, 16'hFFF2},
        {15'h0080, 15'h0080, 1'b0, 1'b1, 16'hFFEC},
        {15'h0208, 15'h0200, 1'b0, 1'b1, 16'hFFE8},
        {15'h0020, 15'h7FFF, 1'b0, 1'b1, 16'hFFF0},
        {15'h0040, 15'h7FFF, 1'b0, 1'b1, 16'hFFEE}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic write_en(input logic [14:0] v);
        en_wr_i = 1'b1; en_wdata_i = v;
        tick(1);
        en_wr_i = 1'b0;
    endtask

    task automatic clear_req();
        req_wr_i = 1'b1; req_wdata_i = '0;
        tick(1);
        req_wr_i = 1'b0; req_wdata_i = '1;
    endtask

    task automatic pulse_tmr(input int i);
        tmr_uf_i[i] = 1'b1;
        tick(1);
        tmr_uf_i[i] = 1'b0;
    endtask

    task automatic pulse_ext(input int i);
        ext_pin_i[i] = 1'b1;
        tick(4);
        ext_pin_i[i] = 1'b0;
        tick(4);
    endtask

    task automatic fire(input int k);
        case (k)
            0:  pulse_ext(0);
            1:  pulse_ext(1);
            2:  begin sio1_rx_i = 1'b1; tick(1); sio1_rx_i = 1'b0; end
            3:  begin sio1_tx_i = 1'b1; tick(1); sio1_tx_i = 1'b0; end
            4:  pulse_tmr(0);
            5:  pulse_tmr(1);
            6:  pulse_tmr(2);
            7:  pulse_tmr(3);
            8:  pulse_ext(3);
            9:  pulse_ext(4);
            10: pulse_tmr(4);
            11: pulse_ext(2);
            12: begin sio2_done_i = 1'b1; tick(1); sio2_done_i = 1'b0; end
            13: begin key_pin_i[0] = 1'b0; tick(4); key_pin_i[0] = 1'b1; tick(4); end
            default: begin ad_done_i = 1'b1; tick(1); ad_done_i = 1'b0; end
        endcase
    endtask

    task automatic do_ack(input logic exp_idis, input string req);
        ack_i = 1'b1;
        #1;
        check(req, 32'(idis_set_o), 32'(exp_idis));
        tick(1);
        ack_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset behaviour
        tick(3);
        check("R1 irq in reset", 32'(irq_o), 32'd1);
        check("R1 vec in reset", 32'(vec_o), 32'hFFFC);
        rst_n = 1'b1;
        tick(2);
        check("R1 irq after reset", 32'(irq_o), 32'd0);
        check("R1 req after reset", 32'(req_o), 32'd0);

        // R2 R4 R8 R9 R11 R12 vector table
        for (int i = 0; i < 11; i++) begin
            clear_req();
            write_en(TBL[i][32:18]);
            for (int k = 0; k < 15; k++) begin
                if (TBL[i][33+k]) fire(k);
            end
            gdis_i = TBL[i][17];
            #1;
            check($sformatf("R12 R4 row %0d latches", i), 32'(req_o), 32'(TBL[i][47:33]));
            check($sformatf("R2 row %0d irq", i), 32'(irq_o), 32'(TBL[i][16]));
            if (TBL[i][16]) check($sformatf("R4 row %0d vec", i), 32'(vec_o), 32'(TBL[i][15:0]));
            tick(1);
            gdis_i = 1'b0;
        end

        // R5 software cannot set, zero clears
        write_en('0);
        clear_req();
        req_wr_i = 1'b1; req_wdata_i = '1; tick(1); req_wr_i = 1'b0;
        check("R5 write ones sets nothing", 32'(req_o), 32'd0);
        fire(4); fire(5);
        req_wr_i = 1'b1; req_wdata_i = ~15'h0010; tick(1); req_wr_i = 1'b0; req_wdata_i = '1;
        check("R5 zero clears one bit", 32'(req_o), 32'h0020);
        req_wr_i = 1'b1; tick(1); req_wr_i = 1'b0;
        check("R5 ones keep latch", 32'(req_o), 32'h0020);

        // R6 set beats clear
        tmr_uf_i[0] = 1'b1; req_wr_i = 1'b1; req_wdata_i = '0;
        tick(1);
        tmr_uf_i[0] = 1'b0; req_wr_i = 1'b0; req_wdata_i = '1;
        check("R6 set wins over clear", 32'(req_o), 32'h0010);

        // R7 acceptance clears only the winner
        write_en('1);
        fire(5);
        check("R7 winner before ack", 32'(vec_o), 32'hFFF2);
        do_ack(1'b1, "R7 idis on accept");
        check("R7 only winner cleared", 32'(req_o), 32'h0020);
        check("R7 next vector", 32'(vec_o), 32'hFFF0);
        clear_req();
        do_ack(1'b0, "R7 no idis when idle");

        // R3 break is unmaskable and lowest
        write_en('0);
        gdis_i = 1'b1;
        brk_i = 1'b1; tick(1); brk_i = 1'b0;
        check("R3 break irq masked", 32'(irq_o), 32'd1);
        check("R3 break vec", 32'(vec_o), 32'hFFDC);
        write_en(15'h0001);
        fire(0);
        check("R3 masked slot hidden", 32'(vec_o), 32'hFFDC);
        gdis_i = 1'b0;
        #1;
        check("R3 break below slot", 32'(vec_o), 32'hFFFA);
        do_ack(1'b1, "R7 accept slot");
        check("R3 break after slot", 32'(vec_o), 32'hFFDC);
        do_ack(1'b1, "R7 accept break");
        check("R3 break cleared", 32'(irq_o), 32'd0);

        // R8 polarity and latency
        write_en('1);
        clear_req();
        ext_rise_i[0] = 1'b0;
        ext_pin_i[0] = 1'b1; tick(5);
        check("R8 rise ignored on falling select", 32'(req_o), 32'd0);
        ext_pin_i[0] = 1'b0;
        tick(2);
        check("R8 not after two edges", 32'(req_o[0]), 32'd0);
        tick(1);
        check("R8 set after three edges", 32'(req_o[0]), 32'd1);
        ext_rise_i[0] = 1'b1;
        tick(3);

        // R9 key wake masking by mode
        clear_req();
        key_inmode_i[0] = 1'b0;
        key_pin_i[0] = 1'b0; tick(5);
        check("R9 output-mode pin ignored", 32'(req_o), 32'd0);
        key_pin_i[0] = 1'b1; tick(4);
        key_inmode_i[0] = 1'b1;
        key_pin_i[3] = 1'b0; tick(4);
        check("R9 input pin fall", 32'(req_o), 32'h2000);
        key_pin_i[3] = 1'b1; tick(4);

        // R10 shared slot select
        clear_req();
        adt_pin_i = 1'b0; tick(4);
        check("R10 trigger ignored when done selected", 32'(req_o), 32'd0);
        adt_pin_i = 1'b1; tick(4);
        ad_sel_i = 1'b0;
        ad_done_i = 1'b1; tick(1); ad_done_i = 1'b0;
        check("R10 done ignored when trigger selected", 32'(req_o), 32'd0);
        adt_pin_i = 1'b0; tick(4);
        check("R10 trigger falling sets slot", 32'(req_o), 32'h4000);
        adt_pin_i = 1'b1; ad_sel_i = 1'b1; tick(4);

        // R11 serial gating
        clear_req();
        sio1_sel_i = 1'b0; sio2_sel_i = 1'b0;
        fire(2); fire(3); fire(12);
        check("R11 deselected serial ignored", 32'(req_o), 32'd0);
        sio1_sel_i = 1'b1; sio2_sel_i = 1'b1;

        // R1 reset mid-run
        fire(6);
        rst_n = 1'b0;
        #1;
        check("R1 vec on reset", 32'(vec_o), 32'hFFFC);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1 latches cleared", 32'(req_o), 32'd0);
        check("R1 irq low after", 32'(irq_o), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule